// File: doc/BRIEF.md
# Page Entry Access Permission Checker

This block decides whether one access may use a 64-bit page table entry. It takes the entry, the kind of access (instruction fetch, data load or data store), whether the processor runs in user (problem) state, whether the check belongs to the partition-level stage of translation, and a three-bit permission mask that software can use to narrow supervisor rights. It returns the permissions the entry grants, a fault flag and a 32-bit cause word that the exception logic can report unchanged.

The decision is made in a fixed order:

1. An instruction fetch from a page marked as non-idempotent I/O is refused as guarded.
2. The granted rights are worked out from the privileged bit, the user flag, the partition flag and the mask.
3. The rights the access needs are compared with the granted rights.
4. Only if that comparison passes are the reference and change bits checked.

The whole decision is combinational. The results are registered once, so every output follows its inputs by one clock.

Entry fields used:

| Field | Bits | Meaning |
|---|---|---|
| Encoded permissions | [2:0] | read = bit 2, write = bit 1, execute = bit 0 |
| Privileged bit | [3] | |
| Attribute | [5:4] | value 2'b11 means non-idempotent I/O |
| Change bit | [7] | |
| Reference bit | [8] | |

All other entry bits are ignored. Cause word bits:

| Bit | Meaning |
|---|---|
| 0 | no-execute / guarded |
| 1 | protection |
| 2 | atomic reference/change |
| 3 | store indicator |
| 31:4 | always zero |

Access codes:

| Code | Access |
|---|---|
| 2'b00 | load |
| 2'b01 | store |
| 2'b10 | fetch |
| 2'b11 | handled as a load |

Top module: `pte_access_checker`

## Requirements
- R1: A fetch (code 2'b10) with attribute field 2'b11 faults with only cause bit 0 set and grants no permissions; no further check runs.
- R2: When the check is not partition-scoped, the privileged bit is set and the user flag is set, the granted permission set is 3'b000.
- R3: Apart from the R1 and R2 cases, when the user flag, the privileged bit or the partition flag is set, the granted set equals entry bits [2:0].
- R4: In every other case (and again apart from R1), the granted set is entry bits [2:0] ANDed bit by bit with mask_i.
- R5: A load (code 2'b00 or 2'b11) needs the read bit (bit 2), a store (code 2'b01) needs the write bit (bit 1), and a fetch needs the execute bit (bit 0).
- R6: If the needed bit is absent from the granted set, the access faults: a fetch with cause bit 0, a load or store with cause bit 1.
- R7: If permission passes, a store with either the reference bit or the change bit clear, or a load or fetch with the reference bit clear, faults with cause bit 2.
- R8: A store that faults under R6 or R7 also has cause bit 3 set; no other fault sets it.
- R9: fault_o is high exactly when cause_o is nonzero, at most one of cause bits 0..2 is set, and the outputs reflect the inputs sampled at the previous rising clock edge.
- R10: While rst_ni is low, perm_o, fault_o and cause_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pte_i | input | 64 | Page table entry under check |
| acc_i | input | 2 | Access code: 00 load, 01 store, 10 fetch, 11 load |
| user_i | input | 1 | Processor in user state |
| part_i | input | 1 | Check belongs to the partition-scoped stage |
| mask_i | input | 3 | Permission mask {read, write, execute} |
| perm_o | output | 3 | Granted permissions {read, write, execute} |
| fault_o | output | 1 | Access refused |
| cause_o | output | 32 | Fault cause word |

## Verification
The hardest case to reach is where several faults could apply at once. For example, a guarded fetch can also lack execute rights and have its reference bit clear, or a store can be denied write rights while its change bit is clear. Only the highest-priority cause may then show.

The bench reaches every such overlap by sweeping all 32768 combinations of the decoded entry fields, access code, user and partition flags and mask. Each result is checked against a priority model computed in the bench.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  localparam int PERM_W = 3;
  localparam int PB_X = 0;
  localparam int PB_W = 1;
  localparam int PB_R = 2;

  localparam int PTE_PERM_LO = 0;
  localparam int PTE_PRIV    = 3;
  localparam int PTE_ATTR_LO = 4;
  localparam int ATTR_W      = 2;
  localparam int PTE_CHG     = 7;
  localparam int PTE_REF     = 8;
  localparam logic [ATTR_W-1:0] ATTR_NIO = 2'b11;

  localparam int CB_NOEXEC = 0;
  localparam int CB_PROT   = 1;
  localparam int CB_RC     = 2;
  localparam int CB_STORE  = 3;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;
endpackage

// File: rtl/pte_need.sv
module pte_need
  import pte_chk_pkg::*;
(
  input  logic [1:0]        acc_i,
  output logic [PERM_W-1:0] need_o,
  output logic              is_store_o,
  output logic              is_fetch_o
);
  always_comb begin
    need_o     = '0;
    is_store_o = 1'b0;
    is_fetch_o = 1'b0;
    unique case (acc_e'(acc_i))
      ACC_STORE: begin
        need_o[PB_W] = 1'b1;
        is_store_o   = 1'b1;
      end
      ACC_FETCH: begin
        need_o[PB_X] = 1'b1;
        is_fetch_o   = 1'b1;
      end
      default: need_o[PB_R] = 1'b1;  // load and reserved code
    endcase
  end
endmodule

// File: rtl/pte_grant.sv
module pte_grant
  import pte_chk_pkg::*;
(
  input  logic [PERM_W-1:0] enc_i,
  input  logic              priv_i,
  input  logic              user_i,
  input  logic              part_i,
  input  logic              guard_i,
  input  logic [PERM_W-1:0] mask_i,
  output logic [PERM_W-1:0] grant_o
);
  logic [PERM_W-1:0] masked;

  for (genvar g = 0; g < PERM_W; g++) begin : g_mask
    assign masked[g] = enc_i[g] & mask_i[g];
  end

  always_comb begin
    if (guard_i)                          grant_o = '0;
    else if (!part_i && priv_i && user_i) grant_o = '0;
    else if (user_i || priv_i || part_i)  grant_o = enc_i;
    else                                  grant_o = masked;
  end
endmodule

// File: rtl/pte_fault.sv
module pte_fault
  import pte_chk_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input  logic [PERM_W-1:0]  grant_i,
  input  logic [PERM_W-1:0]  need_i,
  input  logic               is_store_i,
  input  logic               is_fetch_i,
  input  logic               guard_i,
  input  logic               ref_i,
  input  logic               chg_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic denied, rc_bad;

  assign denied = |(need_i & ~grant_i);
  assign rc_bad = is_store_i ? !(ref_i && chg_i) : !ref_i;

  always_comb begin
    cause_o = '0;
    if (guard_i) begin
      cause_o[CB_NOEXEC] = 1'b1;
    end else if (denied) begin
      if (is_fetch_i) cause_o[CB_NOEXEC] = 1'b1;
      else            cause_o[CB_PROT]   = 1'b1;
      cause_o[CB_STORE] = is_store_i;
    end else if (rc_bad) begin
      cause_o[CB_RC]    = 1'b1;
      cause_o[CB_STORE] = is_store_i;
    end
  end
endmodule

// File: rtl/pte_access_checker.sv
module pte_access_checker
  import pte_chk_pkg::*;
#(
  parameter int PTE_W   = 64,
  parameter int CAUSE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PTE_W-1:0]   pte_i,
  input  logic [1:0]         acc_i,
  input  logic               user_i,
  input  logic               part_i,
  input  logic [PERM_W-1:0]  mask_i,
  output logic [PERM_W-1:0]  perm_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [PERM_W-1:0]  enc, need, grant;
  logic [ATTR_W-1:0]  attr;
  logic               priv, ref_b, chg_b, is_store, is_fetch, guard;
  logic [CAUSE_W-1:0] cause_d;
  logic               unused_pte;

  assign enc   = pte_i[PTE_PERM_LO +: PERM_W];
  assign attr  = pte_i[PTE_ATTR_LO +: ATTR_W];
  assign priv  = pte_i[PTE_PRIV];
  assign ref_b = pte_i[PTE_REF];
  assign chg_b = pte_i[PTE_CHG];
  assign unused_pte = ^{pte_i[PTE_W-1:PTE_REF+1], pte_i[PTE_CHG-1]};

  pte_need u_need (
    .acc_i      (acc_i),
    .need_o     (need),
    .is_store_o (is_store),
    .is_fetch_o (is_fetch)
  );

  assign guard = is_fetch && (attr == ATTR_NIO);

  pte_grant u_grant (
    .enc_i   (enc),
    .priv_i  (priv),
    .user_i  (user_i),
    .part_i  (part_i),
    .guard_i (guard),
    .mask_i  (mask_i),
    .grant_o (grant)
  );

  pte_fault #(.CAUSE_W(CAUSE_W)) u_fault (
    .grant_i    (grant),
    .need_i     (need),
    .is_store_i (is_store),
    .is_fetch_i (is_fetch),
    .guard_i    (guard),
    .ref_i      (ref_b),
    .chg_i      (chg_b),
    .cause_o    (cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perm_o  <= '0;
      fault_o <= 1'b0;
      cause_o <= '0;
    end else begin
      perm_o  <= grant;
      fault_o <= |cause_d;
      cause_o <= cause_d;
    end
  end

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  a_r1_guard_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(acc_i == ACC_FETCH && pte_i[PTE_ATTR_LO +: ATTR_W] == ATTR_NIO)
    |-> fault_o && cause_o[CB_NOEXEC] && perm_o == '0);

  a_r2_user_priv_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(!part_i && user_i && pte_i[PTE_PRIV]) |-> perm_o == '0);

  a_r4_within_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(!part_i && !user_i && !pte_i[PTE_PRIV])
    |-> (perm_o & ~$past(mask_i)) == '0);

  a_r8_store_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && cause_o[CB_STORE] |-> $past(acc_i == ACC_STORE));

  a_r9_one_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o[CB_RC:CB_NOEXEC]) && (fault_o == (cause_o != '0)));

  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> perm_o == '0 && !fault_o && cause_o == '0);
endmodule

// File: tb/pte_access_checker_bench.sv
module pte_access_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0]  acc = '0;
  logic        user = 1'b0, part = 1'b0;
  logic [2:0]  mask = '0;
  logic [2:0]  perm;
  logic        fault;
  logic [31:0] cause;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pte_access_checker u_pte_access_checker (
    .clk_i(clk), .rst_ni(rst_n), .pte_i(pte), .acc_i(acc), .user_i(user),
    .part_i(part), .mask_i(mask), .perm_o(perm), .fault_o(fault), .cause_o(cause)
  );

  logic [35:0] exp_v;
  string       exp_tag;

  task automatic model(input logic [14:0] v, output logic [35:0] e, output string tag);
    logic [1:0] at = v[1:0];
    logic pv = v[2];
    logic [2:0] en = v[5:3];
    logic rf = v[6], ch = v[7];
    logic [1:0] ac = v[9:8];
    logic us = v[10], pa = v[11];
    logic [2:0] mk = v[14:12];
    logic [2:0] g, nd;
    logic [31:0] c;
    bit st = (ac == 2'b01), fe = (ac == 2'b10);
    c = 0;
    // R5: needed right per access code
    nd = fe ? 3'b001 : (st ? 3'b010 : 3'b100);
    if (fe && at == 2'b11) begin g = 0; c[0] = 1; tag = "R1"; end
    else begin
      if (!pa && pv && us) begin g = 0; tag = "R2"; end
      else if (us || pv || pa) begin g = en; tag = "R3"; end
      else begin g = en & mk; tag = "R4"; end
      if ((nd & ~g) != 0) begin
        if (fe) c[0] = 1; else c[1] = 1;
        c[3] = st; tag = st ? "R8" : "R6";
      end else if (st ? !(rf && ch) : !rf) begin
        c[2] = 1; c[3] = st; tag = st ? "R8" : "R7";
      end
    end
    e = {g, (c != 0), c};
  endtask

  task automatic apply(input logic [14:0] v);
    pte = {$urandom(), $urandom()};
    pte[1:0] = v[5:4] & 2'b11;
    pte[2:0] = v[5:3];
    pte[3]   = v[2];
    pte[5:4] = v[1:0];
    pte[7]   = v[7];
    pte[8]   = v[6];
    acc = v[9:8]; user = v[10]; part = v[11]; mask = v[14:12];
  endtask

  task automatic check(input string tag, input logic [35:0] e);
    n_chk++;
    if ({perm, fault, cause} !== e) begin
      n_fail++;
      $display("FAIL %s: got perm=%b fault=%b cause=%h expected perm=%b fault=%b cause=%h",
               tag, perm, fault, cause, e[35:33], e[32], e[31:0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 36'h0);  // reset state
    apply(15'h7fff);
    @(negedge clk);
    check("R10", 36'h0);  // still held in reset with inputs active
    rst_n = 1'b1;
    for (int v = 0; v < 32768; v++) begin
      logic [35:0] e;
      string t;
      apply(15'(v));
      model(15'(v), e, t);
      @(negedge clk);
      check(t, e);  // one-cycle latency (R9)
      exp_v = e; exp_tag = t;
    end
    @(negedge clk);
    check("R9", exp_v);  // held inputs keep the same result
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule